// File: doc/BRIEF.md
# SMBus Alert Line Arbiter

This block drives a device's open-drain alert line. It also answers the SMBus alert-response read. It watches a latched fault register, masked by a per-bit alert enable. It pulls the alert line low when an enabled fault bit becomes set that has not yet produced an alert.

Each fault bit keeps a record that it has already raised an alert. The record clears only when software clears that fault bit. Because of this, a fault that persists or repeats cannot raise the line again. A different bit can, and so can the same bit after it has been cleared and set once more.

When the host reads the alert-response address, a device that is holding the alert line acknowledges. It then shifts out its own 7-bit address. While it shifts, it arbitrates bit by bit on the wired-AND data line. The lowest address wins. The winner lets go of the alert line and the losers keep holding it. A normal read or write addressed to this device also lets go of the line. The byte-level event decoding is done outside this block: START, STOP, address-byte capture, clock edges and the own-address match.

Top module: `smb_alert_arb`

## Requirements
- R1: Out of reset the alert drive and the data-line drive are both inactive (0). The alert drive goes to 1 within two clock cycles after an enabled fault bit becomes set that is not yet recorded as alerted.
- R2: A fault bit whose enable bit is 0 never causes the alert drive to go to 1.
- R3: If the address-byte event carries 8'h19 (address 7'b0001100 with the read bit 1) while the alert drive is 1, the block pulls the data line low from the next SCL falling event until the one after it. This is the acknowledge bit.
- R4: The block drives the data line only while it is answering an alert-response read that it acknowledged. It does not acknowledge when its alert drive is 0, and it does not acknowledge any other address byte.
- R5: After the acknowledge, the block sends the byte {DEV_ADDR, 1'b1} most significant bit first. Each bit is presented on SCL falling events, and the data line is pulled low exactly for the 0 bits.
- R6: If the sampled data line is low at an SCL rising event while the block is presenting a 1, the block has lost. It releases the data line for the rest of the transaction and keeps the alert drive at 1.
- R7: If the block reaches the SCL rising event of the final bit without losing, it releases the alert drive.
- R8: A pulse on the own-address-hit input releases the alert drive.
- R9: After a release, the alert drive returns to 1 only when a different enabled fault bit becomes set, or when an alerted bit is cleared and then set again. A bit that stays set raises no further alert.
- R10: A START or STOP event ends any response in progress, and the data-line drive is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NFLT | Latched fault register bits |
| alert_en_i | input | NFLT | Per-bit alert enables |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| addr_valid_i | input | 1 | First byte after START captured (pulse) |
| addr_byte_i | input | 8 | Captured address byte, read bit in bit 0 |
| scl_fall_i | input | 1 | SCL falling event (pulse) |
| scl_rise_i | input | 1 | SCL rising event (pulse) |
| sda_i | input | 1 | Sampled data line |
| dev_hit_i | input | 1 | This device individually addressed (pulse) |
| alert_pull_o | output | 1 | 1 pulls the alert line low |
| sda_pull_o | output | 1 | 1 pulls the data line low |

## Verification
The bench builds the block with six fault bits and the address 7'h2A. That address mixes 1s and 0s in its upper bits. As a result, a competing device at a random address can win against the block at many different bit positions, and can also lose to it. Six fault bits, with two of them disabled, keep the randomly drawn fault patterns short enough to often hit three cases: a disabled-only change, a persisting bit, and a cleared-then-set bit.

// File: rtl/smb_alert_arb.sv
`timescale 1ns/1ps
module smb_alert_arb #(
  parameter int          NFLT     = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] fault_i,
  input  logic [NFLT-1:0] alert_en_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            addr_valid_i,
  input  logic [7:0]      addr_byte_i,
  input  logic            scl_fall_i,
  input  logic            scl_rise_i,
  input  logic            sda_i,
  input  logic            dev_hit_i,
  output logic            alert_pull_o,
  output logic            sda_pull_o
);
  localparam logic [7:0] ARA_RD  = {7'b0001100, 1'b1};
  localparam logic [7:0] TX_BYTE = {DEV_ADDR, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ACK, S_SEND, S_DONE} st_t;

  st_t             st_q;
  logic [2:0]      idx_q;
  logic [NFLT-1:0] seen_q;
  logic            alert_q;

  wire [NFLT-1:0] armed   = fault_i & alert_en_i;
  wire            new_evt = |(armed & ~seen_q);
  wire            my_bit  = TX_BYTE[idx_q];
  wire            sending = (st_q == S_SEND);
  wire            lost    = sending && scl_rise_i && my_bit && !sda_i;
  wire            won     = sending && scl_rise_i && !lost && (idx_q == 3'd0);
  wire            is_ara  = addr_valid_i && (addr_byte_i == ARA_RD);

  assign alert_pull_o = alert_q;
  assign sda_pull_o   = (st_q == S_ACK) || (sending && !my_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      alert_q <= 1'b0;
    end else begin
      seen_q <= (seen_q | armed) & fault_i;
      if (new_evt)               alert_q <= 1'b1;
      else if (won || dev_hit_i) alert_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= 3'd7;
    end else if (start_i || stop_i) begin
      st_q  <= S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: if (is_ara && alert_q) st_q <= S_WAIT;
        S_WAIT: if (scl_fall_i) st_q <= S_ACK;
        S_ACK:  if (scl_fall_i) begin
                  st_q  <= S_SEND;
                  idx_q <= 3'd7;
                end
        S_SEND: if (lost || won) st_q <= S_DONE;
                else if (scl_fall_i) idx_q <= idx_q - 3'd1;
        S_DONE: st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_alert_arb_chk.sv
`timescale 1ns/1ps
module smb_alert_arb_chk #(
  parameter int NFLT = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NFLT-1:0] fault_i,
  input logic [NFLT-1:0] alert_en_i,
  input logic            stop_i,
  input logic            scl_rise_i,
  input logic            dev_hit_i,
  input logic            alert_pull_o,
  input logic            sda_pull_o
);
  // R2
  alert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_pull_o) |-> $past(|(fault_i & alert_en_i)));

  // R4
  sda_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> alert_pull_o);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !sda_pull_o);

  // R8
  hit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit_i && $stable(fault_i) && $stable(alert_en_i)) |=> !alert_pull_o);

  // R7
  alert_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull_o) |-> ($past(dev_hit_i) || $past(scl_rise_i)));
endmodule

bind smb_alert_arb smb_alert_arb_chk #(.NFLT(NFLT)) u_chk (.*);

// File: tb/smb_alert_arb_bench.sv
`timescale 1ns/1ps
module smb_alert_arb_bench;
  localparam int         NFLT = 6;
  localparam logic [6:0] DEVA = 7'h2A;
  localparam logic [NFLT-1:0] EN = 6'b101101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NFLT-1:0] fault_i = '0, alert_en_i = EN;
  logic start_i = 0, stop_i = 0, addr_valid_i = 0, scl_fall_i = 0, scl_rise_i = 0;
  logic sda_i = 1, dev_hit_i = 0;
  logic [7:0] addr_byte_i = '0;
  logic alert_pull_o, sda_pull_o;

  int n_run = 0, n_fail = 0;
  logic m_alert = 0;
  logic [NFLT-1:0] m_seen = '0;

  always #2.5 clk = ~clk;

  smb_alert_arb #(.NFLT(NFLT), .DEV_ADDR(DEVA)) u_smb_alert_arb (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_fault(input logic [NFLT-1:0] v, input string req);
    logic [NFLT-1:0] fresh;
    fault_i = v;
    tick(); tick();
    fresh  = v & EN & ~m_seen;
    m_seen = (m_seen | (v & EN)) & v;
    if (fresh != '0) m_alert = 1'b1;
    chk(req, alert_pull_o, m_alert);
  endtask

  task automatic hit();
    dev_hit_i = 1; tick(); dev_hit_i = 0; tick();
    m_alert = 1'b0;
    chk("R8", alert_pull_o, 1'b0);
  endtask

  task automatic ara(input logic [7:0] abyte, input logic [6:0] oa, input bit comp, input int abort_bit);
    logic [7:0] mine, oth;
    bit me_in, ot_in;
    mine = {DEVA, 1'b1};
    oth  = {oa, 1'b1};
    start_i = 1; tick(); start_i = 0;
    addr_byte_i = abyte; addr_valid_i = 1; tick(); addr_valid_i = 0;
    chk("R4", sda_pull_o, 1'b0);
    scl_fall_i = 1; tick(); scl_fall_i = 0;
    me_in = m_alert && (abyte == 8'h19);
    ot_in = comp;
    chk(me_in ? "R3" : "R4", sda_pull_o, me_in);
    for (int i = 7; i >= 0; i--) begin
      logic bus;
      scl_fall_i = 1; tick(); scl_fall_i = 0;
      chk(me_in ? "R5" : "R6", sda_pull_o, me_in && !mine[i]);
      if (abort_bit == i) begin
        stop_i = 1; tick(); stop_i = 0;
        chk("R10", sda_pull_o, 1'b0);
        chk("R10", alert_pull_o, m_alert);
        return;
      end
      bus = !sda_pull_o && !(ot_in && !oth[i]);
      sda_i = bus; scl_rise_i = 1; tick(); scl_rise_i = 0; sda_i = 1;
      if (me_in && mine[i] && !bus) me_in = 0;
      if (ot_in && oth[i] && !bus) ot_in = 0;
      if (i == 0 && me_in) m_alert = 1'b0;
    end
    stop_i = 1; tick(); stop_i = 0;
    chk("R7", alert_pull_o, m_alert);
    chk("R10", sda_pull_o, 1'b0);
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'd1234);
    tick(); tick();
    chk("R1", alert_pull_o, 1'b0);
    chk("R1", sda_pull_o, 1'b0);
    rst_n = 1; tick();
    set_fault(6'b000010, "R2");
    set_fault(6'b000011, "R1");
    ara(8'h19, 7'h00, 0, -1);
    set_fault(6'b010011, "R9");
    set_fault(6'b000011, "R9");
    set_fault(6'b000111, "R9");
    ara(8'h19, 7'h10, 1, -1);
    chk("R6", alert_pull_o, 1'b1);
    hit();
    set_fault(6'b000110, "R9");
    set_fault(6'b000111, "R9");
    ara(8'h19, 7'h7F, 0, 4);
    ara(8'h91, 7'h00, 0, -1);
    hit();
    ara(8'h19, 7'h00, 0, -1);
    for (int k = 0; k < 60; k++) begin
      r = $urandom() % 4;
      if (r == 0) set_fault(NFLT'($urandom()), "R9");
      else if (r == 1) hit();
      else begin
        logic [6:0] oa;
        oa = 7'($urandom());
        if (oa == DEVA) oa = oa ^ 7'h01;
        ara(8'h19, oa, ($urandom() % 2) == 1, ($urandom() % 8 == 0) ? int'($urandom() % 8) : -1);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule